// File: doc/BRIEF.md
# Operand Hold Cache

This block is a small, fully associative store for freshly produced results. A superscalar core uses it so that source operands still waiting to commit can be read at dispatch without giving the reorder buffer its own source read ports. Each entry keeps a valid flag, a search key and a result word. The search key is the reorder-buffer slot index of the producing instruction.

Several writeback buses can each deposit one result per cycle. Several dispatch lookup ports search all entries in parallel in the same cycle and each returns a hit flag and the stored word. When a value is not found, the caller falls back to forwarding at commit.

The replacement policy is fixed at elaboration: either oldest-inserted (FIFO) or least-recently-used (LRU). Under LRU, an entry is dropped when its slot commits, so the key stays unique when that slot is reused. A branch misprediction empties the whole store in one cycle.

Top module: `operand_hold_cache`

## Requirements
- R1: After reset no entry is valid, so every enabled lookup misses. Under LRU the recency order starts as entry 0 least recent up to entry N-1 most recent.
- R2: A write on any enabled write port is stored at the next clock edge. From then on, a lookup of that key in the same cycle it is presented returns hit=1 and the written word. A lookup whose enable is low returns hit=0.
- R3: The writes of one cycle that need a fresh entry take consecutive victim candidates in ascending write-port order. Candidates that are the in-place target of another write in the same cycle are skipped.
- R4: A write whose key is already held overwrites that entry in place and uses no victim, so a key is never held twice.
- R5: A lookup presented in the same cycle as a write carrying the same key reports a miss.
- R6: Under FIFO, the victim candidates run from a fill pointer upward, wrapping at N. The pointer starts at 0 and moves past every candidate consumed in the cycle. Lookup hits do not change which entry is replaced.
- R7: Under LRU, the victim candidates are the entries from least to most recent. After each non-flush cycle, every entry that was hit (lookup ports in ascending order) and then every entry that was written (write ports in ascending order) becomes the most recent, in that sequence.
- R8: Under LRU, an enabled commit invalidates the entry holding the committed key unless a write of the same cycle carries that key. Under FIFO the commit input has no effect, and the entry still hits afterwards.
- R9: A flush invalidates every entry at the next edge. It discards the writes of its cycle and leaves the fill pointer and the recency order unchanged.
- R10: All lookup ports work independently and at the same time, each with its own key, hit flag and data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NWR | Per write port: result valid |
| wr_key | input | NWR*KW | Per write port: producing slot index |
| wr_data | input | NWR*DW | Per write port: result word |
| lk_en | input | NLK | Per lookup port: search request |
| lk_key | input | NLK*KW | Per lookup port: slot index searched |
| lk_hit | output | NLK | Per lookup port: value found (same cycle) |
| lk_data | output | NLK*DW | Per lookup port: stored word, meaningful on hit |
| cm_en | input | 1 | A slot commits this cycle |
| cm_key | input | KW | Slot index of the committing instruction |
| flush | input | 1 | Misprediction: drop all entries |

## Verification
The hardest case to reach from the ports is a cycle in which one write updates an entry in place while that entry is also the next victim candidate for another write of the same cycle. Reaching it needs a full store, a victim position that lines up with an existing key, and two writes landing together. The bench draws keys from a space only twice the entry count and keeps both write ports busy, so full stores and key reuse happen often. A behavioural model runs alongside, with a queue for recency and a modulo pointer for FIFO, and every lookup port of a FIFO instance and an LRU instance is compared against it on every cycle. Directed phases before the random run cover capacity overflow with repeated hits, commit, and flush that collides with writes.

// File: rtl/ohc_pkg.sv
package ohc_pkg;
   typedef enum logic {
      REPL_FIFO = 1'b0,
      REPL_LRU  = 1'b1
   } repl_e;
endpackage

// File: rtl/ohc_cam.sv
// Parallel key search over all entries, one result per query port.
module ohc_cam #(
   parameter int N  = 8,
   parameter int KW = 7,
   parameter int NQ = 2,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]           valid,
   input  logic [N-1:0][KW-1:0]   keys,
   input  logic [NQ-1:0][KW-1:0]  q_key,
   output logic [NQ-1:0]          q_hit,
   output logic [NQ-1:0][IW-1:0]  q_idx
);
   for (genvar q = 0; q < NQ; q++) begin : g_q
      logic [N-1:0]  match;
      logic [IW-1:0] idx;
      always_comb begin
         for (int e = 0; e < N; e++)
            match[e] = valid[e] && (keys[e] == q_key[q]);
      end
      always_comb begin
         idx = '0;
         for (int e = 0; e < N; e++)
            if (match[e]) idx = IW'(e);
      end
      assign q_hit[q] = |match;
      assign q_idx[q] = idx;
   end
endmodule

// File: rtl/ohc_order.sv
// Victim candidate ordering: a fill pointer (FIFO) or a recency list (LRU).
module ohc_order
   import ohc_pkg::*;
#(
   parameter int    N      = 8,
   parameter int    NT     = 4,
   parameter repl_e POLICY = REPL_FIFO,
   localparam int   IW     = $clog2(N),
   localparam int   CW     = $clog2(N + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adv,
   input  logic [CW-1:0]         used,
   input  logic [NT-1:0]         t_v,
   input  logic [NT-1:0][IW-1:0] t_idx,
   output logic [N-1:0][IW-1:0]  cand
);
   if (POLICY == REPL_FIFO) begin : g_fifo
      logic [IW-1:0] ptr;
      logic [IW+1:0] psum;
      logic          unused_touch;
      assign unused_touch = ^{t_v, t_idx};

      for (genvar i = 0; i < N; i++) begin : g_c
         logic [IW+1:0] s;
         assign s       = {2'b00, ptr} + (IW+2)'(i);
         assign cand[i] = (s >= (IW+2)'(N)) ? IW'(s - (IW+2)'(N)) : IW'(s);
      end

      assign psum = {2'b00, ptr} + (IW+2)'(used);
      always_ff @(posedge clk) begin
         if (!rst_n)   ptr <= '0;
         else if (adv) ptr <= (psum >= (IW+2)'(N)) ? IW'(psum - (IW+2)'(N)) : IW'(psum);
      end
   end else begin : g_lru
      logic [N-1:0][IW-1:0] ord, nxt;
      logic                 unused_used;
      assign unused_used = ^used;

      always_comb begin
         logic found;
         found = 1'b0;
         nxt   = ord;
         for (int e = 0; e < NT; e++) begin
            if (t_v[e]) begin
               found = 1'b0;
               for (int i = 0; i < N - 1; i++) begin
                  if (nxt[i] == t_idx[e]) found = 1'b1;
                  if (found) nxt[i] = nxt[i+1];
               end
               nxt[N-1] = t_idx[e];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < N; i++) ord[i] <= IW'(i);
         end else if (adv) begin
            ord <= nxt;
         end
      end
      assign cand = ord;

      // R7
      always @(posedge clk) begin
         if (rst_n) begin
            logic [N-1:0] seen;
            seen = '0;
            for (int i = 0; i < N; i++) seen[ord[i]] = 1'b1;
            order_perm_chk: assert (&seen)
               else $error("recency list is not a permutation");
         end
      end
   end
endmodule

// File: rtl/operand_hold_cache.sv
module operand_hold_cache
   import ohc_pkg::*;
#(
   parameter int    ENTRIES = 8,
   parameter int    NWR     = 2,
   parameter int    NLK     = 2,
   parameter int    KW      = 7,
   parameter int    DW      = 32,
   parameter repl_e POLICY  = REPL_FIFO,
   localparam int   IW      = $clog2(ENTRIES),
   localparam int   CW      = $clog2(ENTRIES + 1),
   localparam int   NT      = NLK + NWR
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NWR-1:0]         wr_en,
   input  logic [NWR-1:0][KW-1:0] wr_key,
   input  logic [NWR-1:0][DW-1:0] wr_data,
   input  logic [NLK-1:0]         lk_en,
   input  logic [NLK-1:0][KW-1:0] lk_key,
   output logic [NLK-1:0]         lk_hit,
   output logic [NLK-1:0][DW-1:0] lk_data,
   input  logic                   cm_en,
   input  logic [KW-1:0]          cm_key,
   input  logic                   flush
);
   if (ENTRIES < 2)               begin : g_bad_n  $error("ENTRIES must be at least 2"); end
   if (NWR < 1 || NWR > ENTRIES)  begin : g_bad_w  $error("NWR must be 1..ENTRIES"); end
   if (NLK < 1 || NLK > 2)        begin : g_bad_l  $error("NLK must be 1 or 2"); end
   if ((1 << KW) < ENTRIES)       begin : g_bad_k  $error("KW too narrow"); end

   logic [ENTRIES-1:0]          valid;
   logic [ENTRIES-1:0][KW-1:0]  keys;
   logic [ENTRIES-1:0][DW-1:0]  data;

   logic [NLK-1:0]              lk_found;
   logic [NLK-1:0][IW-1:0]      lk_idx;
   logic [NWR-1:0]              wr_hit;
   logic [NWR-1:0][IW-1:0]      wr_idx;
   logic [0:0]                  cm_hit;
   logic [0:0][IW-1:0]          cm_idx;
   logic [0:0][KW-1:0]          cm_q;

   logic [ENTRIES-1:0][IW-1:0]  cand;
   logic [ENTRIES-1:0]          inpl;
   logic [NWR-1:0][IW-1:0]      tgt;
   logic [CW-1:0]               used_cnt;
   logic [NT-1:0]               t_v;
   logic [NT-1:0][IW-1:0]       t_idx;
   logic                        cm_act;

   assign cm_q[0] = cm_key;

   ohc_cam #(.N(ENTRIES), .KW(KW), .NQ(NLK)) u_lk_cam (
      .valid(valid), .keys(keys), .q_key(lk_key), .q_hit(lk_found), .q_idx(lk_idx));
   ohc_cam #(.N(ENTRIES), .KW(KW), .NQ(NWR)) u_wr_cam (
      .valid(valid), .keys(keys), .q_key(wr_key), .q_hit(wr_hit), .q_idx(wr_idx));
   ohc_cam #(.N(ENTRIES), .KW(KW), .NQ(1)) u_cm_cam (
      .valid(valid), .keys(keys), .q_key(cm_q), .q_hit(cm_hit), .q_idx(cm_idx));

   // Lookup: a same-cycle write of the searched key forces a miss.
   for (genvar q = 0; q < NLK; q++) begin : g_lk
      logic [NWR-1:0] clash;
      for (genvar w = 0; w < NWR; w++) begin : g_cl
         assign clash[w] = wr_en[w] && (wr_key[w] == lk_key[q]);
      end
      assign lk_hit[q]  = lk_en[q] && lk_found[q] && !(|clash);
      assign lk_data[q] = data[lk_idx[q]];
   end

   // Target selection: in-place updates first, then allocation along candidates.
   always_comb begin
      int   cur;
      logic done;
      cur  = 0;
      done = 1'b0;
      inpl = '0;
      for (int w = 0; w < NWR; w++)
         if (wr_en[w] && wr_hit[w]) inpl[wr_idx[w]] = 1'b1;
      for (int w = 0; w < NWR; w++) begin
         tgt[w] = wr_idx[w];
         if (wr_en[w] && !wr_hit[w]) begin
            done = 1'b0;
            for (int j = 0; j < ENTRIES; j++) begin
               if (!done && j >= cur && !inpl[cand[j]]) begin
                  tgt[w] = cand[j];
                  cur    = j + 1;
                  done   = 1'b1;
               end
            end
         end
      end
      used_cnt = CW'(cur);
   end

   for (genvar q = 0; q < NLK; q++) begin : g_tl
      assign t_v[q]   = lk_hit[q];
      assign t_idx[q] = lk_idx[q];
   end
   for (genvar w = 0; w < NWR; w++) begin : g_tw
      assign t_v[NLK+w]   = wr_en[w];
      assign t_idx[NLK+w] = tgt[w];
   end

   ohc_order #(.N(ENTRIES), .NT(NT), .POLICY(POLICY)) u_order (
      .clk(clk), .rst_n(rst_n), .adv(!flush), .used(used_cnt),
      .t_v(t_v), .t_idx(t_idx), .cand(cand));

   if (POLICY == REPL_LRU) begin : g_cm_lru
      assign cm_act = cm_en && cm_hit[0];
   end else begin : g_cm_fifo
      assign cm_act = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= '0;
      end else if (flush) begin
         valid <= '0;
      end else begin
         if (cm_act) valid[cm_idx[0]] <= 1'b0;
         for (int w = 0; w < NWR; w++)
            if (wr_en[w]) valid[tgt[w]] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n && !flush) begin
         for (int w = 0; w < NWR; w++) begin
            if (wr_en[w]) begin
               keys[tgt[w]] <= wr_key[w];
               data[tgt[w]] <= wr_data[w];
            end
         end
      end
   end

   // ---------------- assertions ----------------
   function automatic logic holds_pair(input logic [KW-1:0] k, input logic [DW-1:0] d);
      logic r;
      r = 1'b0;
      for (int e = 0; e < ENTRIES; e++)
         if (valid[e] && keys[e] == k && data[e] == d) r = 1'b1;
      return r;
   endfunction

   function automatic logic holds_key(input logic [KW-1:0] k);
      logic r;
      r = 1'b0;
      for (int e = 0; e < ENTRIES; e++)
         if (valid[e] && keys[e] == k) r = 1'b1;
      return r;
   endfunction

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid == '0));

   for (genvar w = 0; w < NWR; w++) begin : g_cap
      // R2
      write_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && wr_en[w] && !flush) |-> holds_pair($past(wr_key[w]), $past(wr_data[w])));
   end

   // R4
   always @(posedge clk) begin
      if (rst_n) begin
         logic dup;
         dup = 1'b0;
         for (int i = 0; i < ENTRIES; i++)
            for (int j = i + 1; j < ENTRIES; j++)
               if (valid[i] && valid[j] && keys[i] == keys[j]) dup = 1'b1;
         unique_key_chk: assert (!dup) else $error("key held twice");
      end
   end

   if (POLICY == REPL_LRU) begin : g_cm_chk
      logic cm_wr_same;
      always_comb begin
         cm_wr_same = 1'b0;
         for (int w = 0; w < NWR; w++)
            if (wr_en[w] && wr_key[w] == cm_key) cm_wr_same = 1'b1;
      end
      // R8
      commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n && cm_en && !flush && !cm_wr_same) |-> !holds_key($past(cm_key)));
   end
endmodule

// File: tb/tb_operand_hold_cache.sv
`timescale 1ns/1ps
module tb_operand_hold_cache;
   import ohc_pkg::*;
   localparam int ENT = 8, NW = 2, NL = 2, KW = 7, DW = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                  rst_n;
   logic [NW-1:0]         wr_en;
   logic [NW-1:0][KW-1:0] wr_key;
   logic [NW-1:0][DW-1:0] wr_data;
   logic [NL-1:0]         lk_en;
   logic [NL-1:0][KW-1:0] lk_key;
   logic [NL-1:0]         hit_f, hit_l;
   logic [NL-1:0][DW-1:0] dat_f, dat_l;
   logic                  cm_en;
   logic [KW-1:0]         cm_key;
   logic                  flush;

   operand_hold_cache #(.ENTRIES(ENT), .NWR(NW), .NLK(NL), .KW(KW), .DW(DW), .POLICY(REPL_FIFO)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_data(wr_data),
      .lk_en(lk_en), .lk_key(lk_key), .lk_hit(hit_f), .lk_data(dat_f),
      .cm_en(cm_en), .cm_key(cm_key), .flush(flush));
   operand_hold_cache #(.ENTRIES(ENT), .NWR(NW), .NLK(NL), .KW(KW), .DW(DW), .POLICY(REPL_LRU)) dut_lru (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_data(wr_data),
      .lk_en(lk_en), .lk_key(lk_key), .lk_hit(hit_l), .lk_data(dat_l),
      .cm_en(cm_en), .cm_key(cm_key), .flush(flush));

   // reference model: index 0 = FIFO instance, 1 = LRU instance
   bit             mv [2][ENT];
   int             mk [2][ENT];
   logic [DW-1:0]  md [2][ENT];
   int             fptr;
   int             lq[$];
   int             n_chk = 0, n_fail = 0;
   string          tag = "R1";
   bit             done_flag = 0;

   function automatic int find(int p, int k);
      for (int e = 0; e < ENT; e++) if (mv[p][e] && mk[p][e] == k) return e;
      return -1;
   endfunction

   function automatic bit exp_hit(int p, int q, output logic [DW-1:0] d);
      int e;
      d = '0;
      if (!lk_en[q]) return 0;
      for (int w = 0; w < NW; w++) if (wr_en[w] && wr_key[w] == lk_key[q]) return 0;
      e = find(p, int'(lk_key[q]));
      if (e < 0) return 0;
      d = md[p][e];
      return 1;
   endfunction

   task automatic compare();
      for (int p = 0; p < 2; p++) begin
         for (int q = 0; q < NL; q++) begin
            logic [DW-1:0] ed, ad;
            bit eh;
            logic ah;
            eh = exp_hit(p, q, ed);
            ah = p ? hit_l[q] : hit_f[q];
            ad = p ? dat_l[q] : dat_f[q];
            n_chk++;
            if (ah !== eh || (eh && ad !== ed)) begin
               n_fail++;
               $display("FAIL %s policy=%0d port=%0d key=%0d: hit/data %b/%h expected %b/%h",
                        tag, p, q, lk_key[q], ah, ad, eh, ed);
            end
         end
      end
   endtask

   task automatic model_update(int p);
      int tgt[NW];
      bit inpl[ENT];
      int cand[ENT];
      int cur;
      int touch[$];
      logic [DW-1:0] dd;
      if (flush) begin
         for (int e = 0; e < ENT; e++) mv[p][e] = 0;
         return;
      end
      for (int q = 0; q < NL; q++)
         if (exp_hit(p, q, dd)) touch.push_back(find(p, int'(lk_key[q])));
      for (int e = 0; e < ENT; e++) inpl[e] = 0;
      for (int w = 0; w < NW; w++) begin
         tgt[w] = -1;
         if (wr_en[w]) begin
            tgt[w] = find(p, int'(wr_key[w]));
            if (tgt[w] >= 0) inpl[tgt[w]] = 1;
         end
      end
      for (int i = 0; i < ENT; i++) cand[i] = (p == 0) ? (fptr + i) % ENT : lq[i];
      cur = 0;
      for (int w = 0; w < NW; w++) begin
         if (wr_en[w] && tgt[w] < 0) begin
            while (inpl[cand[cur]]) cur++;
            tgt[w] = cand[cur];
            cur++;
         end
      end
      if (p == 1 && cm_en) begin
         int c;
         c = find(p, int'(cm_key));
         if (c >= 0) mv[p][c] = 0;
      end
      for (int w = 0; w < NW; w++) begin
         if (wr_en[w]) begin
            mv[p][tgt[w]] = 1;
            mk[p][tgt[w]] = int'(wr_key[w]);
            md[p][tgt[w]] = wr_data[w];
            touch.push_back(tgt[w]);
         end
      end
      if (p == 0) fptr = (fptr + cur) % ENT;
      else begin
         foreach (touch[t]) begin
            for (int i = 0; i < lq.size(); i++)
               if (lq[i] == touch[t]) begin lq.delete(i); break; end
            lq.push_back(touch[t]);
         end
      end
   endtask

   task automatic step();
      #1 compare();
      @(posedge clk);
      model_update(0);
      model_update(1);
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = '0; lk_en = '0; cm_en = 1'b0; flush = 1'b0;
   endtask

   task automatic wr(int w, int k, logic [DW-1:0] d);
      wr_en[w] = 1'b1; wr_key[w] = KW'(k); wr_data[w] = d;
   endtask

   task automatic lk(int q, int k);
      lk_en[q] = 1'b1; lk_key[q] = KW'(k);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      #(4 * 200000);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_key = '0; wr_data = '0; lk_key = '0; cm_key = '0;
      idle();
      for (int e = 0; e < ENT; e++) begin mv[0][e] = 0; mv[1][e] = 0; lq.push_back(e); end
      fptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: empty after reset
      tag = "R1"; lk(0, 0); lk(1, 5); step();

      // R2: store then hit; disabled lookup gives no hit
      tag = "R2"; idle(); wr(0, 5, 32'h7); lk(1, 6); step();
      idle(); lk(0, 5); step();
      idle(); lk_key[1] = 7'd5; step();

      // R5: lookup and write of one key together
      tag = "R5"; idle(); wr(0, 9, 32'h99); lk(0, 9); lk(1, 5); step();
      idle(); lk(0, 9); step();

      // R3: two allocations in one cycle
      tag = "R3"; idle(); wr(0, 20, 32'h20); wr(1, 21, 32'h21); step();
      idle(); lk(0, 20); lk(1, 21); step();

      // R4: in-place overwrite next to an allocating write
      tag = "R4"; idle(); wr(0, 22, 32'h22); wr(1, 5, 32'h55); step();
      idle(); lk(0, 5); lk(1, 22); step();

      // R10: independent ports
      tag = "R10"; idle(); lk(0, 21); lk(1, 9); step();
      idle(); lk(0, 9); lk(1, 40); step();

      // R6 R7: overflow while keeping key 5 hot
      tag = "R6 R7";
      for (int i = 0; i < 10; i++) begin
         idle(); wr(0, 30 + 2 * i, 32'(i)); wr(1, 31 + 2 * i, 32'(100 + i)); lk(0, 5); step();
      end
      for (int k = 0; k < 52; k += 2) begin
         idle(); lk(0, k); lk(1, k + 1); step();
      end

      // R8: commit of a held key
      tag = "R8"; idle(); wr(0, 80, 32'h80); step();
      idle(); cm_en = 1'b1; cm_key = 7'd80; step();
      idle(); lk(0, 80); step();

      // R9: flush beats writes
      tag = "R9"; idle(); flush = 1'b1; wr(0, 90, 32'h90); lk(0, 80); step();
      idle(); lk(0, 90); lk(1, 80); step();

      // mixed random traffic over a small key space
      tag = "R3 R4 R6 R7 R8 R9";
      for (int c = 0; c < 3000; c++) begin
         idle();
         for (int w = 0; w < NW; w++)
            if ($urandom % 4 != 0) wr(w, int'($urandom % 16), $urandom);
         if (wr_en[0] && wr_en[1] && wr_key[0] == wr_key[1]) wr_en[1] = 1'b0;
         for (int q = 0; q < NL; q++)
            if ($urandom % 4 != 0) lk(q, int'($urandom % 16));
         if ($urandom % 5 == 0) begin cm_en = 1'b1; cm_key = KW'($urandom % 16); end
         flush = ($urandom % 40 == 0);
         step();
      end

      done_flag = 1;
      summary();
      $finish;
   end
endmodule